// File: doc/BRIEF.md
# PWM Fault Guard

This block sits between a PWM generator and the output pins. It watches two independent fault inputs, both active low. When either input is enabled and low, it replaces every PWM output with a programmable safe value. The pin inputs are first passed through a synchronizer. After that, the override path is combinational, so the outputs change in the same cycle that the synchronized fault appears.

Each fault channel has its own enable and mode. In latched mode a fault sets a sticky interrupt flag. The outputs stay overridden until three things have happened in order: the pin has gone high again, software has cleared the flag, and the PWM time base has signalled a period or half-period boundary. In cycle-by-cycle mode there is no flag, and the override drops at the first boundary after the pin is high again.

Reset puts both channels in the enabled, latched state with both flags set and all safe values low. Power-up is therefore fail-safe, and software must clear both flags before PWM can reach the pins.

Top module: `pwm_fault_guard`

## Requirements
- R1: When an enabled fault pin is driven low, every `pwm_out` bit equals its safe value. This takes effect once the two synchronizer stages have passed the low level, which is after the second rising edge that samples the pin low.
- R2: A high fault pin causes no override, and neither does a low pin on a disabled channel. In both cases `pwm_out` follows `pwm_in`.
- R3: After reset, both channels are enabled and latched. `flag_a` and `flag_b` read 1, all safe values are 0, and `pwm_out` is all zeros.
- R4: In latched mode, an enabled low pin sets that channel's flag. The flag stays set until it is cleared.
- R5: A write to address 3 clears flags: data bit 0 clears A and bit 1 clears B. The clear takes effect only if that channel's synchronized pin is high. While the pin is still low the clear is ignored and the flag stays 1.
- R6: A latched override is released only by a strobe on `bnd_period` or `bnd_half`, and only after the pin is high and the flag has been cleared. A boundary that arrives while the flag is still set does not release it.
- R7: In cycle-by-cycle mode a fault never sets the flag. The override is released at the first boundary strobe after the synchronized pin is high, with no clear needed.
- R8: Clearing the fault condition by itself does not release the outputs. They stay at the safe value until a boundary strobe arrives.
- R9: A write to address 2 loads the safe value for each output, with bit i belonging to `pwm_out[i]`.
- R10: Address 0 controls channel A and address 1 controls channel B. In those registers, data bit 0 is the enable and data bit 1 selects the mode: 0 for latched, 1 for cycle-by-cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_a_n | input | 1 | Fault pin A, active low |
| flt_b_n | input | 1 | Fault pin B, active low |
| pwm_in | input | NUM_OUT | Outputs from the PWM generator |
| bnd_period | input | 1 | Period boundary strobe |
| bnd_half | input | 1 | Half-period boundary strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DW | Register write data |
| pwm_out | output | NUM_OUT | Guarded PWM outputs |
| flag_a | output | 1 | Sticky fault flag for channel A |
| flag_b | output | 1 | Sticky fault flag for channel B |
| fault_active | output | 1 | High while any override is in force |

## Verification
A pin change reaches `pwm_out` after two rising edges. The channel's flag and hold state then update on the third edge. Register writes and boundary strobes each take effect at the single edge that samples them.

The bench drives all inputs and samples all outputs on falling edges. It waits exactly two edges after a pin change before checking the override. It waits one more edge before checking a flag. It checks the release or the ignored effect right after the edge that consumed the write or the strobe. Each release check comes straight after a check that the outputs were still held before the boundary.

// File: rtl/pwmflt_pkg.sv
package pwmflt_pkg;

    typedef enum logic {
        FMODE_LATCH = 1'b0,
        FMODE_CYCLE = 1'b1
    } fmode_e;

    // bit 1 = mode, bit 0 = enable
    typedef struct packed {
        fmode_e mode;
        logic   en;
    } fctl_t;

    localparam int NUM_FAULTS = 2;

    localparam logic [1:0] ADDR_CTL_A = 2'd0;
    localparam logic [1:0] ADDR_CTL_B = 2'd1;
    localparam logic [1:0] ADDR_SAFE  = 2'd2;
    localparam logic [1:0] ADDR_CLR   = 2'd3;

    localparam fctl_t CTL_RESET = '{mode: FMODE_LATCH, en: 1'b1};

    function automatic fctl_t decode_ctl(input logic [1:0] d);
        fctl_t c;
        c.en   = d[0];
        c.mode = d[1] ? FMODE_CYCLE : FMODE_LATCH;
        return c;
    endfunction

endpackage

// File: rtl/pwmflt_sync.sv
module pwmflt_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    initial begin
        if (STAGES < 2) $error("pwmflt_sync needs at least two stages");
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL}};
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/pwmflt_regs.sv
module pwmflt_regs
    import pwmflt_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter int DW      = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DW-1:0]      wr_data,
    output fctl_t              ctl_a,
    output fctl_t              ctl_b,
    output logic [NUM_OUT-1:0] safe_val,
    output logic [1:0]         clr_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_a    <= CTL_RESET;
            ctl_b    <= CTL_RESET;
            safe_val <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTL_A: ctl_a    <= decode_ctl(wr_data[1:0]);
                ADDR_CTL_B: ctl_b    <= decode_ctl(wr_data[1:0]);
                ADDR_SAFE:  safe_val <= wr_data[NUM_OUT-1:0];
                default:    ;
            endcase
        end
    end

    assign clr_req = (wr_en && wr_addr == ADDR_CLR) ? wr_data[1:0] : 2'b00;
endmodule

// File: rtl/pwmflt_channel.sv
module pwmflt_channel
    import pwmflt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flt,
    input  fctl_t ctl,
    input  logic  clr,
    input  logic  bnd,
    output logic  trip,
    output logic  flag
);
    logic held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b1;
            flag <= 1'b1;
        end else begin
            if (!ctl.en)
                held <= 1'b0;
            else if (flt)
                held <= 1'b1;
            else if (bnd && (ctl.mode == FMODE_CYCLE || !flag))
                held <= 1'b0;

            if (ctl.en && flt && ctl.mode == FMODE_LATCH)
                flag <= 1'b1;
            else if (clr && !flt)
                flag <= 1'b0;
        end
    end

    assign trip = ctl.en & (flt | held);

    p_latch_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && flt && ctl.mode == FMODE_LATCH) |=> flag);

    p_clr_ignored_low_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && flt && flag) |=> flag);

    p_release_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(held) |-> ($past(bnd) || !$past(ctl.en)));

    p_latch_release_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(held) && $past(ctl.en) && $past(ctl.mode) == FMODE_LATCH) |-> !$past(flag));
endmodule

// File: rtl/pwmflt_override.sv
module pwmflt_override #(
    parameter int NUM_OUT = 6
) (
    input  logic               force_safe,
    input  logic [NUM_OUT-1:0] pwm_in,
    input  logic [NUM_OUT-1:0] safe_val,
    output logic [NUM_OUT-1:0] pwm_out
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign pwm_out[i] = force_safe ? safe_val[i] : pwm_in[i];
    end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pwmflt_pkg::*;
#(
    parameter int NUM_OUT     = 6,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = (NUM_OUT > 2) ? NUM_OUT : 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flt_a_n,
    input  logic               flt_b_n,
    input  logic [NUM_OUT-1:0] pwm_in,
    input  logic               bnd_period,
    input  logic               bnd_half,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DW-1:0]      wr_data,
    output logic [NUM_OUT-1:0] pwm_out,
    output logic               flag_a,
    output logic               flag_b,
    output logic               fault_active
);
    logic [NUM_FAULTS-1:0] flt_s;
    logic [NUM_FAULTS-1:0] trip;
    logic [NUM_FAULTS-1:0] flag;
    logic [1:0]            clr_req;
    logic [NUM_OUT-1:0]    safe_val;
    fctl_t                 ctl_a, ctl_b;
    fctl_t                 ctl [NUM_FAULTS];
    logic                  bnd;

    pwmflt_sync #(.WIDTH(NUM_FAULTS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({~flt_b_n, ~flt_a_n}),
        .q   (flt_s)
    );

    pwmflt_regs #(.NUM_OUT(NUM_OUT), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctl_a    (ctl_a),
        .ctl_b    (ctl_b),
        .safe_val (safe_val),
        .clr_req  (clr_req)
    );

    assign ctl[0] = ctl_a;
    assign ctl[1] = ctl_b;
    assign bnd    = bnd_period | bnd_half;

    for (genvar c = 0; c < NUM_FAULTS; c++) begin : g_chan
        pwmflt_channel u_chan (
            .clk  (clk),
            .rst  (rst),
            .flt  (flt_s[c]),
            .ctl  (ctl[c]),
            .clr  (clr_req[c]),
            .bnd  (bnd),
            .trip (trip[c]),
            .flag (flag[c])
        );
    end

    assign fault_active = |trip;
    assign flag_a       = flag[0];
    assign flag_b       = flag[1];

    pwmflt_override #(.NUM_OUT(NUM_OUT)) u_ovr (
        .force_safe (fault_active),
        .pwm_in     (pwm_in),
        .safe_val   (safe_val),
        .pwm_out    (pwm_out)
    );

    p_fault_a_forces_r1: assert property (@(posedge clk) disable iff (rst)
        (flt_s[0] && ctl_a.en) |-> (pwm_out == safe_val));

    p_fault_b_forces_r1: assert property (@(posedge clk) disable iff (rst)
        (flt_s[1] && ctl_b.en) |-> (pwm_out == safe_val));

    p_cycle_no_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_a.mode == FMODE_CYCLE && !flag_a && !clr_req[0]) |=> !flag_a);
endmodule

// File: tb/pwm_fault_guard_tb.sv
`timescale 1ns/1ps
module pwm_fault_guard_tb;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         flt_a_n, flt_b_n;
    logic [N-1:0] pwm_in;
    logic         bnd_period, bnd_half;
    logic         wr_en;
    logic [1:0]   wr_addr;
    logic [N-1:0] wr_data;
    logic [N-1:0] pwm_out;
    logic         flag_a, flag_b, fault_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pwm_fault_guard #(.NUM_OUT(N)) u_dut (
        .clk(clk), .rst(rst), .flt_a_n(flt_a_n), .flt_b_n(flt_b_n),
        .pwm_in(pwm_in), .bnd_period(bnd_period), .bnd_half(bnd_half),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .flag_a(flag_a), .flag_b(flag_b),
        .fault_active(fault_active)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic strobe(input bit half);
        if (half) bnd_half = 1'b1; else bnd_period = 1'b1;
        step(1);
        bnd_half = 1'b0; bnd_period = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; flt_a_n = 1'b1; flt_b_n = 1'b1;
        pwm_in = 6'b110011; bnd_period = 0; bnd_half = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0;
        step(3);
        rst = 1'b0;
        chk("R3 out after reset", 8'(pwm_out), 8'h00);
        chk("R3 flag_a", 8'(flag_a), 8'h1);
        chk("R3 flag_b", 8'(flag_b), 8'h1);
        step(2);
        wr(2'd3, 6'b000011);
        chk("R5 flags cleared", 8'({flag_b, flag_a}), 8'h0);
        chk("R8 held until boundary", 8'(pwm_out), 8'h00);
        strobe(0);
        chk("R6 released by period", 8'(pwm_out), 8'(pwm_in));
    endtask

    task automatic t_latched_a();
        pwm_in = 6'b011101;
        flt_a_n = 1'b0;
        step(2);
        chk("R1 override on A", 8'(pwm_out), 8'h00);
        step(1);
        chk("R4 flag_a set", 8'(flag_a), 8'h1);
        wr(2'd3, 6'b000001);
        chk("R5 clear ignored while low", 8'(flag_a), 8'h1);
        flt_a_n = 1'b1;
        step(2);
        strobe(1);
        chk("R6 boundary with flag set keeps override", 8'(pwm_out), 8'h00);
        wr(2'd3, 6'b000001);
        chk("R5 flag_a cleared", 8'(flag_a), 8'h0);
        chk("R8 still held after clear", 8'(pwm_out), 8'h00);
        strobe(1);
        chk("R6 released by half", 8'(pwm_out), 8'(pwm_in));
    endtask

    task automatic t_safe_b();
        wr(2'd2, 6'b101010);
        flt_b_n = 1'b0;
        step(2);
        chk("R9 safe values on B fault", 8'(pwm_out), 8'h2A);
        chk("R1 fault_active", 8'(fault_active), 8'h1);
        flt_b_n = 1'b1;
        step(2);
        wr(2'd3, 6'b000010);
        strobe(0);
        chk("R6 B released", 8'(pwm_out), 8'(pwm_in));
    endtask

    task automatic t_cycle_a();
        wr(2'd0, 6'b000011);
        pwm_in = 6'b100110;
        flt_a_n = 1'b0;
        step(2);
        chk("R10 cycle mode override", 8'(pwm_out), 8'h2A);
        step(1);
        chk("R7 no flag in cycle mode", 8'(flag_a), 8'h0);
        flt_a_n = 1'b1;
        step(2);
        chk("R8 cycle held before boundary", 8'(pwm_out), 8'h2A);
        strobe(0);
        chk("R7 cycle released without clear", 8'(pwm_out), 8'(pwm_in));
        wr(2'd0, 6'b000001);
    endtask

    task automatic t_disabled_b();
        wr(2'd1, 6'b000000);
        flt_b_n = 1'b0;
        step(4);
        chk("R2 disabled B no override", 8'(pwm_out), 8'(pwm_in));
        chk("R10 disabled B no flag", 8'(flag_b), 8'h0);
        flt_b_n = 1'b1;
        step(2);
        wr(2'd1, 6'b000001);
        chk("R2 re-enabled, pin high", 8'(pwm_out), 8'(pwm_in));
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 3; i++) begin
            pwm_in = 6'(6'b010101 << i) ^ 6'(i * 7);
            step(1);
            chk("R2 pass-through", 8'(pwm_out), 8'(pwm_in));
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_latched_a();
        t_safe_b();
        t_cycle_a();
        t_disabled_b();
        t_patterns();
        summary();
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule